// File: doc/BRIEF.md
# Relative Branch Execution Unit

This unit executes the two-byte relative branch group and the branch-to-subroutine call for an 8-bit accumulator CPU. The fetch stage hands it one instruction at a time: the opcode, the signed offset byte, the address of the opcode, a snapshot of the interrupt-mask and arithmetic flags, the level of the external interrupt pin and the current stack pointer. The unit works out the next program counter, reports whether the branch was taken, and raises a one-cycle completion strobe. For a call it also drives a byte-wide stack write port to save the return address.

The instruction input is a valid/ready stream. The unit raises `in_ready` only when it is idle. A transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. While the unit is busy it holds `in_ready` low, so the producer must keep its instruction, or present a new one, until `in_ready` returns. Whatever sits on the inputs during busy cycles is ignored. The completion side is a plain strobe with no back-pressure. The outputs are valid in the cycle where `done` is high and they hold until the next accepted instruction. A new instruction can be accepted on the edge that ends the `done` cycle.

The condition-code bits are only read. This unit never writes them.

Top module: `rel_branch_unit`

## Requirements
- R1: For a branch, `next_pc` is the fall-through address (`in_pc`+2) when the branch is not taken. When it is taken, `next_pc` is the fall-through address plus the sign-extended `in_offset`. All arithmetic wraps modulo 2^16.
- R2: Opcode 0x20 is always taken and opcode 0x21 is never taken. Both take the full branch duration.
- R3: `in_ccr` bit 3 is the interrupt mask I, bit 2 is N, bit 1 is Z and bit 0 is C. Opcode 0x24 is taken when C is clear, 0x25 when C is set, and 0x23 when C or Z is set.
- R4: Opcode 0x26 is taken when Z is clear, 0x2A when N is clear, and 0x2B when N is set.
- R5: Opcode 0x2C is taken when I is clear, and 0x2D when I is set.
- R6: Opcode 0x2E is taken when `in_irq` is low, and 0x2F when `in_irq` is high. The pin level is sampled at acceptance.
- R7: A branch raises `done` in the third cycle counted from the acceptance edge. `in_ready` stays low until then, and `sp_out` equals `in_sp`.
- R8: Opcode 0xAD raises `done` in the sixth cycle and reports `taken`=1. It writes the low byte of `in_pc`+2 at address `in_sp`, then the high byte at `in_sp`-1. It reports `sp_out` = `in_sp`-2 and `next_pc` = `in_pc`+2+offset.
- R9: Any other opcode raises `done` and `illegal` in the first cycle, with `taken`=0, `next_pc`=`in_pc`, `sp_out`=`in_sp`, and no stack write.
- R10: The stack pointer wraps within 8 bits. A call with `in_sp`=0x00 writes at 0x00 and 0xFF and reports `sp_out`=0xFE.
- R11: The input is taken only when `in_valid` and `in_ready` are both high. Inputs presented while busy have no effect on the result or on the stack writes, and no stack write happens while `in_ready` is high.
- R12: During reset `in_ready` is 1, and `done` and `stk_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit idle, instruction will be taken |
| in_opcode | input | 8 | Opcode byte |
| in_offset | input | 8 | Signed branch displacement |
| in_pc | input | 16 | Address of the opcode |
| in_ccr | input | 4 | Flags {I, N, Z, C} |
| in_irq | input | 1 | External interrupt pin level |
| in_sp | input | 8 | Current stack pointer |
| done | output | 1 | One-cycle completion strobe |
| next_pc | output | 16 | Next program counter |
| taken | output | 1 | Branch or call was taken |
| illegal | output | 1 | Opcode not supported |
| sp_out | output | 8 | Stack pointer after the instruction |
| stk_we | output | 1 | Stack byte write enable |
| stk_addr | output | 8 | Stack write address |
| stk_wdata | output | 8 | Stack write data |

## Verification
The three result latencies are fixed: an illegal opcode completes 1 cycle after acceptance, a branch 3 cycles after, and a call 6 cycles after. The two stack writes of a call land on the second and third edges after acceptance. The bench counts falling edges from the acceptance edge until `done` is seen and compares that count with the latency expected for the opcode. Only then does it read `next_pc`, `taken`, `illegal` and `sp_out`, and check the stack model. In every busy cycle it checks that `in_ready` is low and drives random junk with `in_valid` high. Any result that depends on those inputs would therefore show up as a mismatch.

// File: rtl/rbu_pkg.sv
package rbu_pkg;

  localparam logic [7:0] OP_ALWAYS = 8'h20;
  localparam logic [7:0] OP_NEVER  = 8'h21;
  localparam logic [7:0] OP_LOSAME = 8'h23;
  localparam logic [7:0] OP_CCLR   = 8'h24;
  localparam logic [7:0] OP_CSET   = 8'h25;
  localparam logic [7:0] OP_ZCLR   = 8'h26;
  localparam logic [7:0] OP_NCLR   = 8'h2A;
  localparam logic [7:0] OP_NSET   = 8'h2B;
  localparam logic [7:0] OP_ICLR   = 8'h2C;
  localparam logic [7:0] OP_ISET   = 8'h2D;
  localparam logic [7:0] OP_PINLO  = 8'h2E;
  localparam logic [7:0] OP_PINHI  = 8'h2F;
  localparam logic [7:0] OP_CALL   = 8'hAD;

  typedef enum logic [1:0] {
    K_ILLEGAL = 2'd0,
    K_BRANCH  = 2'd1,
    K_CALL    = 2'd2
  } kind_t;

  // flag snapshot, bit 3 down to bit 0
  typedef struct packed {
    logic i;
    logic n;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/rbu_cond_decode.sv
module rbu_cond_decode
  import rbu_pkg::*;
(
  input  logic [7:0] opcode,
  input  flags_t     flags,
  input  logic       irq_lvl,
  output kind_t      kind,
  output logic       cond_met
);

  always_comb begin
    kind     = K_BRANCH;
    cond_met = 1'b0;
    case (opcode)
      OP_ALWAYS: cond_met = 1'b1;
      OP_NEVER:  cond_met = 1'b0;
      OP_LOSAME: cond_met = flags.c | flags.z;
      OP_CCLR:   cond_met = ~flags.c;
      OP_CSET:   cond_met = flags.c;
      OP_ZCLR:   cond_met = ~flags.z;
      OP_NCLR:   cond_met = ~flags.n;
      OP_NSET:   cond_met = flags.n;
      OP_ICLR:   cond_met = ~flags.i;
      OP_ISET:   cond_met = flags.i;
      OP_PINLO:  cond_met = ~irq_lvl;
      OP_PINHI:  cond_met = irq_lvl;
      OP_CALL: begin
        kind     = K_CALL;
        cond_met = 1'b1;
      end
      default:   kind = K_ILLEGAL;
    endcase
  end

endmodule

// File: rtl/rbu_target_calc.sv
module rbu_target_calc #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8,
  parameter int INSN_LEN = 2
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  output logic [PC_W-1:0]  ret_addr,
  output logic [PC_W-1:0]  target
);

  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;

  assign off_ext  = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign ret_addr = pc + PC_W'(INSN_LEN);
  assign target   = ret_addr + off_ext;

endmodule

// File: rtl/rbu_seq.sv
module rbu_seq
  import rbu_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int SP_W     = 8,
  parameter int BYTE_W   = 8,
  parameter int BR_CYC   = 3,
  parameter int CALL_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  kind_t             kind,
  input  logic              cond_met,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-1:0]   ret_addr,
  input  logic [PC_W-1:0]   target,
  input  logic [SP_W-1:0]   sp_in,
  output logic              done,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic              illegal,
  output logic [SP_W-1:0]   sp_out,
  output logic              stk_we,
  output logic [SP_W-1:0]   stk_addr,
  output logic [BYTE_W-1:0] stk_wdata
);

  localparam int CNT_W = $clog2(CALL_CYC);
  localparam logic [CNT_W-1:0] CNT_BR   = CNT_W'(BR_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_CALL = CNT_W'(CALL_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_LO   = CNT_W'(CALL_CYC - 2);
  localparam logic [CNT_W-1:0] CNT_HI   = CNT_W'(CALL_CYC - 3);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             call_r;
  logic [PC_W-1:0]  ret_r;
  logic [SP_W-1:0]  sp_r;
  logic             accept;
  logic             push_lo;
  logic             push_hi;

  assign in_ready = ~busy;
  assign accept   = in_valid & ~busy;
  assign push_lo  = busy & call_r & (cnt == CNT_LO);
  assign push_hi  = busy & call_r & (cnt == CNT_HI);

  assign stk_we    = push_lo | push_hi;
  assign stk_addr  = sp_r;
  assign stk_wdata = push_lo ? ret_r[BYTE_W-1:0] : ret_r[2*BYTE_W-1:BYTE_W];
  assign sp_out    = sp_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      call_r  <= 1'b0;
      ret_r   <= '0;
      sp_r    <= '0;
      done    <= 1'b0;
      next_pc <= '0;
      taken   <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        sp_r   <= sp_in;
        ret_r  <= ret_addr;
        call_r <= (kind == K_CALL);
        case (kind)
          K_BRANCH: begin
            busy    <= 1'b1;
            cnt     <= CNT_BR;
            next_pc <= cond_met ? target : ret_addr;
            taken   <= cond_met;
            illegal <= 1'b0;
          end
          K_CALL: begin
            busy    <= 1'b1;
            cnt     <= CNT_CALL;
            next_pc <= target;
            taken   <= 1'b1;
            illegal <= 1'b0;
          end
          default: begin
            done    <= 1'b1;
            next_pc <= pc;
            taken   <= 1'b0;
            illegal <= 1'b1;
          end
        endcase
      end else if (busy) begin
        cnt <= cnt - CNT_ONE;
        if (stk_we) sp_r <= sp_r - SP_W'(1);
        if (cnt == CNT_ONE) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
  import rbu_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8,
  parameter int SP_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_opcode,
  input  logic [OFF_W-1:0] in_offset,
  input  logic [PC_W-1:0]  in_pc,
  input  logic [3:0]       in_ccr,
  input  logic             in_irq,
  input  logic [SP_W-1:0]  in_sp,
  output logic             done,
  output logic [PC_W-1:0]  next_pc,
  output logic             taken,
  output logic             illegal,
  output logic [SP_W-1:0]  sp_out,
  output logic             stk_we,
  output logic [SP_W-1:0]  stk_addr,
  output logic [7:0]       stk_wdata
);

  kind_t           kind;
  logic            cond_met;
  logic [PC_W-1:0] ret_addr;
  logic [PC_W-1:0] target;

  rbu_cond_decode u_dec (
    .opcode   (in_opcode),
    .flags    (flags_t'(in_ccr)),
    .irq_lvl  (in_irq),
    .kind     (kind),
    .cond_met (cond_met)
  );

  rbu_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W), .INSN_LEN(2)) u_tgt (
    .pc       (in_pc),
    .offset   (in_offset),
    .ret_addr (ret_addr),
    .target   (target)
  );

  rbu_seq #(.PC_W(PC_W), .SP_W(SP_W), .BYTE_W(8), .BR_CYC(3), .CALL_CYC(6)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .kind      (kind),
    .cond_met  (cond_met),
    .pc        (in_pc),
    .ret_addr  (ret_addr),
    .target    (target),
    .sp_in     (in_sp),
    .done      (done),
    .next_pc   (next_pc),
    .taken     (taken),
    .illegal   (illegal),
    .sp_out    (sp_out),
    .stk_we    (stk_we),
    .stk_addr  (stk_addr),
    .stk_wdata (stk_wdata)
  );

endmodule

// File: rtl/rel_branch_unit_chk.sv
module rel_branch_unit_chk #(
  parameter int PC_W = 16,
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [PC_W-1:0] in_pc,
  input logic [SP_W-1:0] in_sp,
  input logic            done,
  input logic [PC_W-1:0] next_pc,
  input logic            taken,
  input logic            illegal,
  input logic [SP_W-1:0] sp_out,
  input logic            stk_we,
  input logic [SP_W-1:0] stk_addr
);

  AST_BUSY_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> $past(!in_ready)); // R7

  AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && !$past(stk_we)) |=> (stk_we && stk_addr == $past(stk_addr) - SP_W'(1))); // R8

  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (!taken && next_pc == $past(in_pc) && sp_out == $past(in_sp))); // R9

  AST_NO_PUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !stk_we); // R11

  AST_TAKE_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid)); // R11

endmodule

bind rel_branch_unit rel_branch_unit_chk #(.PC_W(PC_W), .SP_W(SP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_pc    (in_pc),
  .in_sp    (in_sp),
  .done     (done),
  .next_pc  (next_pc),
  .taken    (taken),
  .illegal  (illegal),
  .sp_out   (sp_out),
  .stk_we   (stk_we),
  .stk_addr (stk_addr)
);

// File: tb/rel_branch_unit_tb.sv
module rel_branch_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic [7:0]  in_offset = '0;
  logic [15:0] in_pc = '0;
  logic [3:0]  in_ccr = '0;
  logic        in_irq = 1'b0;
  logic [7:0]  in_sp = '0;
  logic        done;
  logic [15:0] next_pc;
  logic        taken;
  logic        illegal;
  logic [7:0]  sp_out;
  logic        stk_we;
  logic [7:0]  stk_addr;
  logic [7:0]  stk_wdata;

  int checks = 0;
  int errors = 0;
  int wr_count = 0;
  logic [7:0] stack_mem [256];

  always #2 clk = ~clk;

  rel_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_offset(in_offset), .in_pc(in_pc),
    .in_ccr(in_ccr), .in_irq(in_irq), .in_sp(in_sp), .done(done),
    .next_pc(next_pc), .taken(taken), .illegal(illegal), .sp_out(sp_out),
    .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata)
  );

  always @(posedge clk) begin
    if (stk_we) begin
      stack_mem[stk_addr] <= stk_wdata;
      wr_count <= wr_count + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // returns {legal, call, taken}; flags are {I,N,Z,C}
  function automatic logic [2:0] model(input logic [7:0] op, input logic [3:0] f,
                                       input logic irq);
    case (op)
      8'h20: return 3'b101;
      8'h21: return 3'b100;
      8'h23: return {2'b10, f[0] | f[1]};
      8'h24: return {2'b10, ~f[0]};
      8'h25: return {2'b10, f[0]};
      8'h26: return {2'b10, ~f[1]};
      8'h2A: return {2'b10, ~f[2]};
      8'h2B: return {2'b10, f[2]};
      8'h2C: return {2'b10, ~f[3]};
      8'h2D: return {2'b10, f[3]};
      8'h2E: return {2'b10, ~irq};
      8'h2F: return {2'b10, irq};
      8'hAD: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'h20, 8'h21: return "R2";
      8'h23, 8'h24, 8'h25: return "R3";
      8'h26, 8'h2A, 8'h2B: return "R4";
      8'h2C, 8'h2D: return "R5";
      8'h2E, 8'h2F: return "R6";
      8'hAD: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [7:0] off,
                        input logic [15:0] pc, input logic [3:0] f,
                        input logic irq, input logic [7:0] sp);
    logic [2:0]  m;
    logic [15:0] ret;
    logic [15:0] tgt;
    logic [15:0] exp_pc;
    logic [7:0]  exp_sp;
    int          exp_lat;
    int          n;
    int          wr0;
    string       rq;
    m   = model(op, f, irq);
    rq  = req_of(op);
    ret = pc + 16'd2;
    tgt = ret + {{8{off[7]}}, off};
    if (!m[2]) begin
      exp_pc = pc; exp_sp = sp; exp_lat = 1;
    end else if (m[1]) begin
      exp_pc = tgt; exp_sp = sp - 8'd2; exp_lat = 6;
    end else begin
      exp_pc = m[0] ? tgt : ret; exp_sp = sp; exp_lat = 3;
    end
    @(negedge clk);
    wr0 = wr_count;
    in_opcode = op; in_offset = off; in_pc = pc; in_ccr = f; in_irq = irq; in_sp = sp;
    in_valid = 1'b1;
    chk("R11", "ready idle", in_ready, 1);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!done) begin
        chk("R11", "ready busy", in_ready, 0);
        in_valid  = 1'b1;
        in_opcode = 8'($urandom);
        in_offset = 8'($urandom);
        in_pc     = 16'($urandom);
        in_ccr    = 4'($urandom);
        in_irq    = 1'($urandom);
        in_sp     = 8'($urandom);
      end else begin
        in_valid = 1'b0;
      end
    end while (!done && n < 20);
    chk(m[2] ? (m[1] ? "R8" : "R7") : "R9", "latency", n, exp_lat);
    chk("R1", "next_pc", next_pc, exp_pc);
    chk(rq, "taken", taken, {31'd0, m[0]});
    chk("R9", "illegal", illegal, {31'd0, ~m[2]});
    chk(m[1] ? "R8" : "R7", "sp_out", sp_out, exp_sp);
    chk(m[1] ? "R8" : "R11", "writes", wr_count - wr0, m[1] ? 2 : 0);
    if (m[1]) begin
      chk("R8", "low byte", stack_mem[sp], ret[7:0]);
      chk("R10", "high byte", stack_mem[sp - 8'd1], ret[15:8]);
    end
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R12", "ready in reset", in_ready, 1);
    chk("R12", "done in reset", done, 0);
    chk("R12", "we in reset", stk_we, 0);
    rst_n = 1'b1;
    // directed: each condition both ways
    run_op(8'h20, 8'h10, 16'h1000, 4'h0, 1'b0, 8'hFF);
    run_op(8'h21, 8'h10, 16'h1000, 4'hF, 1'b1, 8'hFF);
    run_op(8'h23, 8'hF0, 16'h2000, 4'b0010, 1'b0, 8'h80);
    run_op(8'h23, 8'hF0, 16'h2000, 4'b1100, 1'b0, 8'h80);
    run_op(8'h24, 8'h05, 16'h3000, 4'b0000, 1'b0, 8'h80);
    run_op(8'h25, 8'h05, 16'h3000, 4'b0000, 1'b0, 8'h80);
    run_op(8'h26, 8'h7F, 16'h4000, 4'b0010, 1'b0, 8'h80);
    run_op(8'h2A, 8'h80, 16'h4000, 4'b0000, 1'b0, 8'h80);
    run_op(8'h2B, 8'h80, 16'h4000, 4'b0100, 1'b0, 8'h80);
    run_op(8'h2C, 8'h02, 16'h5000, 4'b1000, 1'b0, 8'h80);
    run_op(8'h2D, 8'h02, 16'h5000, 4'b1000, 1'b0, 8'h80);
    run_op(8'h2E, 8'h02, 16'h6000, 4'b0000, 1'b1, 8'h80);
    run_op(8'h2F, 8'h02, 16'h6000, 4'b0000, 1'b1, 8'h80);
    run_op(8'h20, 8'h01, 16'hFFFE, 4'b0000, 1'b0, 8'h80);
    // calls, including the stack pointer wrap case (R10)
    run_op(8'hAD, 8'h80, 16'h12FF, 4'b0000, 1'b0, 8'h40);
    run_op(8'hAD, 8'h20, 16'hABCD, 4'b0000, 1'b0, 8'h00);
    run_op(8'hAD, 8'h00, 16'h00FE, 4'b0000, 1'b0, 8'h01);
    // unsupported opcodes
    run_op(8'h22, 8'h10, 16'h7000, 4'b0000, 1'b0, 8'h33);
    run_op(8'hFF, 8'h10, 16'h7001, 4'b0000, 1'b0, 8'h34);
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [7:0] op;
      case ($urandom % 16)
        0: op = 8'h20;  1: op = 8'h21;  2: op = 8'h23;  3: op = 8'h24;
        4: op = 8'h25;  5: op = 8'h26;  6: op = 8'h2A;  7: op = 8'h2B;
        8: op = 8'h2C;  9: op = 8'h2D;  10: op = 8'h2E; 11: op = 8'h2F;
        12, 13: op = 8'hAD;
        default: op = 8'($urandom);
      endcase
      run_op(op, 8'($urandom), 16'($urandom), 4'($urandom), 1'($urandom), 8'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule